// File: doc/BRIEF.md
# Host Mailbox Interface

This block sits between an 8-bit ISA-style host I/O bus and a local microprocessor. The host sees three port-mapped registers at a base address that is set by a parameter. At offset 0 it passes a data byte each way. At offset 1 it writes a command byte and reads a status byte. At offset 2 it writes a control byte that drives the local CPU's run enable, single-step enable, debug interrupt request and memory mode select.

The host strobes are asynchronous to the local clock. Each strobe is brought into the local domain through a two-flop synchroniser. The block acts once per access, on the strobe's rising edge. The local CPU uses a small synchronous register bus with an interrupt output. The interrupt is raised whenever an inbound data or command byte is waiting.

Both sides can see the handshake flags. The host polls the status byte until the inbound flag has cleared and the reply flag has set. As an option, the block holds the host's ready line low during a data write until the local CPU has taken the byte. When both sides touch the same register in the same clock cycle, the host access wins.

Top module: `hostMailbox`

## Requirements
- R1: After reset the status byte is zero, `locIrq` is low, `cpuRun`, `stepEn` and `dbgIrq` are low, and `romMode` is high.
- R2: A host access is decoded only when `hostAen` is low, `hostAddr[9:2]` equals `BASE[9:2]` (`BASE` is a multiple of 4), and `hostAddr[1:0]` is 0, 1 or 2. Any other access changes no state and does not drive the bus.
- R3: A host write at offset 0 stores the byte, sets the inbound flag (status bit 0) and raises `locIrq`. A local read at `locAddr` 0 returns that byte and clears the flag.
- R4: A host write at offset 1 stores the command, sets the command flag (status bit 2) and raises `locIrq`. A local read at `locAddr` 1 returns the command and clears the flag.
- R5: A local write at `locAddr` 0 stores the reply byte and sets the reply flag (status bit 1). A host read at offset 0 returns the reply byte and clears the reply flag.
- R6: A host write at offset 2 sets `cpuRun` from bit 0, `stepEn` from bit 1, `dbgIrq` from bit 2 and `romMode` from the inverse of bit 3. A host read at offset 2 returns the control byte in bits 3..0.
- R7: The status byte is read at host offset 1 and at local `locAddr` 2. Bits 7..3 read zero.
- R8: The effect of a host strobe lands on the third rising clock edge at which the strobe is seen high. A strobe held high for many cycles counts as one access.
- R9: If a host data write and a local data read fall in the same cycle, the inbound flag stays set. If a host data read and a local data write fall in the same cycle, the local write is dropped and the reply flag is cleared.
- R10: `hostDataOe` is high only while `hostIor` is high on a decoded address. `hostDataOut` then carries the register selected by the offset.
- R11: With `stretchEn` high, `hostRdy` is low while `hostIow` is high on offset 0, until the write has been taken and the local CPU has read the byte. In every other case `hostRdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 10 | Host I/O address |
| hostDataIn | input | 8 | Host write data |
| hostDataOut | output | 8 | Host read data |
| hostDataOe | output | 1 | Host data bus drive enable |
| hostAen | input | 1 | DMA cycle marker; a high value blocks decoding |
| hostIor | input | 1 | Host I/O read strobe, active high |
| hostIow | input | 1 | Host I/O write strobe, active high |
| hostRdy | output | 1 | Host ready; low stretches the cycle |
| stretchEn | input | 1 | Enables stretching of host data writes |
| locSel | input | 1 | Local bus access this cycle |
| locWr | input | 1 | Local access is a write |
| locAddr | input | 2 | Local register select |
| locWdata | input | 8 | Local write data |
| locRdata | output | 8 | Local read data |
| locIrq | output | 1 | Interrupt to the local CPU |
| cpuRun | output | 1 | Run/ready enable for the local CPU |
| stepEn | output | 1 | Single-step enable |
| dbgIrq | output | 1 | Debug interrupt request |
| romMode | output | 1 | High selects monitor ROM, low selects program RAM |

## Verification
The collisions in R9 are the hardest case to reach from the ports. The local access has to fall exactly on the clock edge where the synchronised host strobe takes effect, and that edge is hidden behind two synchroniser flops. The bench raises the host strobe just after a falling clock edge. It then counts two falling edges and drives the local access for the single cycle in which the host event is applied. It does this for both collision pairs. A reference model, advanced on every rising edge, then confirms the surviving flag values.

// File: rtl/hostMailboxPkg.sv
package hostMailboxPkg;
  localparam logic [1:0] OFF_DATA = 2'd0;
  localparam logic [1:0] OFF_CMD  = 2'd1;
  localparam logic [1:0] OFF_CTRL = 2'd2;
  localparam int ST_IN   = 0;
  localparam int ST_RESP = 1;
  localparam int ST_CMD  = 2;
  localparam int CTRL_W  = 4;

  typedef struct packed {
    logic hWrData;
    logic hWrCmd;
    logic hWrCtrl;
    logic hRdData;
    logic lRdData;
    logic lRdCmd;
    logic lWrData;
  } strobeT;
endpackage

// File: rtl/hostMailboxCtrl.sv
module hostMailboxCtrl
  import hostMailboxPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h300,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostAen,
  input  logic              hostIor,
  input  logic              hostIow,
  input  logic              stretchEn,
  input  logic              locSel,
  input  logic              locWr,
  input  logic [1:0]        locAddr,
  input  logic              inAvail,
  output strobeT            stb,
  output logic [1:0]        hostOff,
  output logic              hostDataOe,
  output logic              hostRdy
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [1:0] strobeRaw;
  logic [1:0] strobeEv;
  logic [1:0] strobeLvl;
  logic       hit;
  logic       wrPend;

  assign strobeRaw = {hostIor, hostIow};

  for (genvar g = 0; g < 2; g++) begin : gSync
    logic [SH_W-1:0] sh;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sh <= '0;
      else       sh <= {sh[SH_W-2:0], strobeRaw[g]};
    end
    assign strobeLvl[g] = sh[SYNC_STAGES-1];
    assign strobeEv[g]  = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  end

  assign hostOff = hostAddr[1:0];
  assign hit = !hostAen && (hostAddr[ADDR_W-1:2] == BASE[ADDR_W-1:2])
               && (hostAddr[1:0] != 2'd3);

  always_comb begin
    stb = '0;
    stb.hWrData = strobeEv[0] && hit && hostOff == OFF_DATA;
    stb.hWrCmd  = strobeEv[0] && hit && hostOff == OFF_CMD;
    stb.hWrCtrl = strobeEv[0] && hit && hostOff == OFF_CTRL;
    stb.hRdData = strobeEv[1] && hit && hostOff == OFF_DATA;
    stb.lRdData = locSel && !locWr && locAddr == OFF_DATA && !stb.hWrData;
    stb.lRdCmd  = locSel && !locWr && locAddr == OFF_CMD && !stb.hWrCmd;
    stb.lWrData = locSel && locWr && locAddr == OFF_DATA && !stb.hRdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wrPend <= 1'b0;
    else if (stb.hWrData)   wrPend <= 1'b1;
    else if (!strobeLvl[0]) wrPend <= 1'b0;
  end

  assign hostDataOe = hostIor && hit;
  assign hostRdy = !(stretchEn && hostIow && hit && hostOff == OFF_DATA
                     && (!wrPend || inAvail));
endmodule

// File: rtl/hostMailboxDp.sv
module hostMailboxDp
  import hostMailboxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     stb,
  input  logic [1:0] hostOff,
  input  logic [7:0] hostDataIn,
  input  logic [1:0] locAddr,
  input  logic       locSel,
  input  logic [7:0] locWdata,
  output logic [7:0] hostDataOut,
  output logic [7:0] locRdata,
  output logic       inAvail,
  output logic       locIrq,
  output logic [CTRL_W-1:0] ctrlReg
);
  logic [7:0] inByte, cmdByte, outByte, status;
  logic       respAvail, cmdAvail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inByte <= '0; cmdByte <= '0; outByte <= '0; ctrlReg <= '0;
      inAvail <= 1'b0; respAvail <= 1'b0; cmdAvail <= 1'b0;
    end else begin
      if (stb.hWrData)      begin inByte <= hostDataIn; inAvail <= 1'b1; end
      else if (stb.lRdData) inAvail <= 1'b0;
      if (stb.hWrCmd)       begin cmdByte <= hostDataIn; cmdAvail <= 1'b1; end
      else if (stb.lRdCmd)  cmdAvail <= 1'b0;
      if (stb.hRdData)      respAvail <= 1'b0;
      else if (stb.lWrData) begin outByte <= locWdata; respAvail <= 1'b1; end
      if (stb.hWrCtrl)      ctrlReg <= hostDataIn[CTRL_W-1:0];
    end
  end

  always_comb begin
    status = '0;
    status[ST_IN]   = inAvail;
    status[ST_RESP] = respAvail;
    status[ST_CMD]  = cmdAvail;
  end

  always_comb begin
    case (hostOff)
      OFF_DATA: hostDataOut = outByte;
      OFF_CMD:  hostDataOut = status;
      OFF_CTRL: hostDataOut = {{(8-CTRL_W){1'b0}}, ctrlReg};
      default:  hostDataOut = '0;
    endcase
  end

  always_comb begin
    locRdata = '0;
    if (locSel) begin
      case (locAddr)
        OFF_DATA: locRdata = inByte;
        OFF_CMD:  locRdata = cmdByte;
        2'd2:     locRdata = status;
        default:  locRdata = '0;
      endcase
    end
  end

  assign locIrq = inAvail | cmdAvail;
endmodule

// File: rtl/hostMailbox.sv
module hostMailbox
  import hostMailboxPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h300,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostDataIn,
  output logic [7:0]        hostDataOut,
  output logic              hostDataOe,
  input  logic              hostAen,
  input  logic              hostIor,
  input  logic              hostIow,
  output logic              hostRdy,
  input  logic              stretchEn,
  input  logic              locSel,
  input  logic              locWr,
  input  logic [1:0]        locAddr,
  input  logic [7:0]        locWdata,
  output logic [7:0]        locRdata,
  output logic              locIrq,
  output logic              cpuRun,
  output logic              stepEn,
  output logic              dbgIrq,
  output logic              romMode
);
  strobeT            stb;
  logic [1:0]        hostOff;
  logic              inAvail;
  logic [CTRL_W-1:0] ctrlReg;

  hostMailboxCtrl #(.ADDR_W(ADDR_W), .BASE(BASE), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostAen(hostAen),
    .hostIor(hostIor), .hostIow(hostIow), .stretchEn(stretchEn),
    .locSel(locSel), .locWr(locWr), .locAddr(locAddr), .inAvail(inAvail),
    .stb(stb), .hostOff(hostOff), .hostDataOe(hostDataOe), .hostRdy(hostRdy)
  );

  hostMailboxDp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostOff(hostOff),
    .hostDataIn(hostDataIn), .locAddr(locAddr), .locSel(locSel),
    .locWdata(locWdata), .hostDataOut(hostDataOut), .locRdata(locRdata),
    .inAvail(inAvail), .locIrq(locIrq), .ctrlReg(ctrlReg)
  );

  assign cpuRun  = ctrlReg[0];
  assign stepEn  = ctrlReg[1];
  assign dbgIrq  = ctrlReg[2];
  assign romMode = !ctrlReg[3];
endmodule

// File: rtl/hostMailboxChk.sv
module hostMailboxChk (
  input logic clk,
  input logic rstN,
  input logic hostIor,
  input logic hostIow,
  input logic hostAen,
  input logic hostDataOe,
  input logic hostRdy,
  input logic stretchEn,
  input logic locIrq,
  input logic cpuRun,
  input logic stepEn,
  input logic dbgIrq,
  input logic romMode
);
  // R1: reset state of the outputs
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (!locIrq && romMode && !cpuRun && !stepEn && !dbgIrq));

  // R10: the bus is driven only during a non-DMA host read
  a_r10_oe_only_read: assert property (@(posedge clk) disable iff (!rstN)
    hostDataOe |-> (hostIor && !hostAen));

  // R11: a wait is inserted only on a stretched host write
  a_r11_rdy_low_cause: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdy |-> (hostIow && stretchEn));

  // R8: the interrupt rises only after a write strobe three edges earlier
  a_r8_irq_latency: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locIrq) |-> $past(hostIow, 3));

  // R6: control outputs change only after a write strobe
  a_r6_ctrl_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    !$past(hostIow, 3) |-> $stable({cpuRun, stepEn, dbgIrq, romMode}));
endmodule

bind hostMailbox hostMailboxChk u_chk (
  .clk(clk), .rstN(rstN), .hostIor(hostIor), .hostIow(hostIow),
  .hostAen(hostAen), .hostDataOe(hostDataOe), .hostRdy(hostRdy),
  .stretchEn(stretchEn), .locIrq(locIrq), .cpuRun(cpuRun), .stepEn(stepEn),
  .dbgIrq(dbgIrq), .romMode(romMode)
);

// File: tb/hostMailbox_tb.sv
module hostMailbox_tb;
  localparam int PERIOD = 10;
  localparam logic [9:0] BASE = 10'h300;

  logic clk = 0, rstN = 0;
  logic [9:0] hostAddr = '0;
  logic [7:0] hostDataIn = '0, locWdata = '0;
  logic hostAen = 0, hostIor = 0, hostIow = 0, stretchEn = 0;
  logic locSel = 0, locWr = 0;
  logic [1:0] locAddr = '0;
  logic [7:0] hostDataOut, locRdata;
  logic hostDataOe, hostRdy, locIrq, cpuRun, stepEn, dbgIrq, romMode;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  hostMailbox #(.BASE(BASE)) u_dut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int mIn, mCmd, mOut, mCtrl;
  bit mInA, mRespA, mCmdA, mPend;
  bit w1, w2, w3, r1, r2, r3;

  function automatic bit hitNow();
    return !hostAen && hostAddr >= BASE && hostAddr <= BASE + 2;
  endfunction

  function automatic int statusNow();
    return (mCmdA << 2) | (mRespA << 1) | mInA;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mIn = 0; mCmd = 0; mOut = 0; mCtrl = 0;
      mInA = 0; mRespA = 0; mCmdA = 0; mPend = 0;
      w1 = 0; w2 = 0; w3 = 0; r1 = 0; r2 = 0; r3 = 0;
    end else begin
      automatic bit evW = w2 && !w3;
      automatic bit evR = r2 && !r3;
      automatic int off = hostAddr - BASE;
      automatic bit hw0 = evW && hitNow() && off == 0;
      automatic bit hw1 = evW && hitNow() && off == 1;
      automatic bit hw2 = evW && hitNow() && off == 2;
      automatic bit hr0 = evR && hitNow() && off == 0;
      if (locSel && !locWr && locAddr == 0) mInA = 0;
      if (hw0) begin mIn = hostDataIn; mInA = 1; end
      if (locSel && !locWr && locAddr == 1) mCmdA = 0;
      if (hw1) begin mCmd = hostDataIn; mCmdA = 1; end
      if (locSel && locWr && locAddr == 0 && !hr0) begin mOut = locWdata; mRespA = 1; end
      if (hr0) mRespA = 0;
      if (hw2) mCtrl = hostDataIn & 15;
      if (!w2) mPend = 0;
      if (hw0) mPend = 1;
      w3 = w2; w2 = w1; w1 = hostIow;
      r3 = r2; r2 = r1; r1 = hostIor;
    end
  end

  // per-clock comparison, away from both edges
  always @(negedge clk) begin
    #1;
    if (!done) begin
      automatic int off = hostAddr - BASE;
      automatic int expOut = (off == 0) ? mOut : (off == 1) ? statusNow() : mCtrl;
      automatic bit expOe = hostIor && hitNow();
      automatic bit expRdy = !(stretchEn && hostIow && hitNow() && off == 0 && (!mPend || mInA));
      chk("R10 oe", hostDataOe, expOe);
      if (expOe) chk("R10 data", hostDataOut, expOut);
      chk("R11 rdy", hostRdy, expRdy);
      chk("R3 R4 irq", locIrq, mInA | mCmdA);
      chk("R6 ctrl", {cpuRun, stepEn, dbgIrq, romMode},
          {mCtrl[0], mCtrl[1], mCtrl[2], !mCtrl[3]});
      if (locSel && !locWr)
        chk("R7 locRdata", locRdata,
            (locAddr == 0) ? mIn : (locAddr == 1) ? mCmd : (locAddr == 2) ? statusNow() : 0);
    end
  end

  task automatic hostWrite(logic [9:0] a, logic [7:0] d, bit aen = 0);
    @(negedge clk);
    hostAddr = a; hostDataIn = d; hostAen = aen; hostIow = 1;
    repeat (4) @(negedge clk);
    hostIow = 0;
    repeat (3) @(negedge clk);
    hostAen = 0;
  endtask

  task automatic hostRead(logic [9:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostIor = 1;
    #1 d = hostDataOut;
    repeat (4) @(negedge clk);
    hostIor = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic locRead(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    locSel = 1; locWr = 0; locAddr = a;
    #1 d = locRdata;
    @(negedge clk);
    locSel = 0;
  endtask

  task automatic locWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    locSel = 1; locWr = 1; locAddr = a; locWdata = d;
    @(negedge clk);
    locSel = 0; locWr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", locIrq, 0);
    chk("R1 romMode", romMode, 1);
    chk("R1 run", cpuRun, 0);
    locRead(2, d); chk("R1 status", d, 0);

    // R3 inbound data byte
    hostWrite(BASE, 8'hA5);
    chk("R3 irq set", locIrq, 1);
    locRead(2, d); chk("R3 status bit0", d, 8'h01);
    locRead(0, d); chk("R3 data", d, 8'hA5);
    locRead(2, d); chk("R3 cleared", d, 0);

    // R4 command byte
    hostWrite(BASE + 1, 8'h3C);
    hostRead(BASE + 1, d); chk("R7 host status", d, 8'h04);
    locRead(1, d); chk("R4 cmd", d, 8'h3C);
    chk("R4 irq clear", locIrq, 0);

    // R5 reply path
    locWrite(0, 8'h5A);
    hostRead(BASE + 1, d); chk("R5 resp flag", d, 8'h02);
    hostRead(BASE, d); chk("R5 reply", d, 8'h5A);
    locRead(2, d); chk("R5 resp cleared", d, 0);

    // R6 control register
    hostWrite(BASE + 2, 8'h0D);
    chk("R6 run", cpuRun, 1); chk("R6 step", stepEn, 0);
    chk("R6 dbg", dbgIrq, 1); chk("R6 ram", romMode, 0);
    hostRead(BASE + 2, d); chk("R6 readback", d, 8'h0D);
    hostWrite(BASE + 2, 8'h02);
    chk("R6 step only", {cpuRun, stepEn, dbgIrq, romMode}, 4'b0101);

    // R2 ignored accesses
    hostWrite(BASE, 8'h11, 1);
    hostWrite(BASE + 3, 8'h22);
    hostWrite(10'h200, 8'h33);
    chk("R2 no irq", locIrq, 0);
    locRead(2, d); chk("R2 status", d, 0);
    @(negedge clk); hostAddr = BASE + 3; hostIor = 1;
    #1 chk("R2 no oe", hostDataOe, 0);
    @(negedge clk); hostIor = 0;

    // R8 long strobe: single event, latency of three edges
    @(negedge clk);
    hostAddr = BASE + 1; hostDataIn = 8'h77; hostIow = 1;
    @(negedge clk); #1 chk("R8 edge1", locIrq, 0);
    @(negedge clk); #1 chk("R8 edge2", locIrq, 0);
    @(negedge clk); #1 chk("R8 edge3", locIrq, 1);
    locRead(1, d); chk("R8 cmd", d, 8'h77);
    repeat (6) @(negedge clk);
    #1 chk("R8 single event", locIrq, 0);
    hostIow = 0;
    repeat (3) @(negedge clk);

    // R9 collision: host data write vs local data read
    @(negedge clk);
    hostAddr = BASE; hostDataIn = 8'h99; hostIow = 1;
    @(negedge clk);
    @(negedge clk); locSel = 1; locWr = 0; locAddr = 0;
    @(negedge clk); locSel = 0;
    repeat (2) @(negedge clk); hostIow = 0;
    repeat (3) @(negedge clk);
    locRead(2, d); chk("R9 in flag kept", d, 8'h01);
    locRead(0, d); chk("R9 data", d, 8'h99);

    // R9 collision: host data read vs local data write
    locWrite(0, 8'h44);
    @(negedge clk);
    hostAddr = BASE; hostIor = 1;
    @(negedge clk);
    @(negedge clk); locSel = 1; locWr = 1; locAddr = 0; locWdata = 8'hEE;
    @(negedge clk); locSel = 0; locWr = 0;
    repeat (2) @(negedge clk); hostIor = 0;
    repeat (3) @(negedge clk);
    locRead(2, d); chk("R9 resp dropped", d, 0);
    hostRead(BASE, d); chk("R9 reply unchanged", d, 8'h44);

    // R11 stretched data write
    stretchEn = 1;
    @(negedge clk);
    hostAddr = BASE; hostDataIn = 8'hC3; hostIow = 1;
    #1 chk("R11 rdy low", hostRdy, 0);
    repeat (6) @(negedge clk);
    #1 chk("R11 still low", hostRdy, 0);
    locRead(0, d); chk("R11 byte", d, 8'hC3);
    #1 chk("R11 released", hostRdy, 1);
    hostIow = 0;
    repeat (3) @(negedge clk);
    stretchEn = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule